// File: doc/BRIEF.md
# Pseudo-Random Scan Pattern Loader

This block produces pseudo-random stimulus for a chain of launch flip-flops and shifts it in serially. A 32-bit Galois LFSR supplies one new bit on every scan clock. A scheduler drives the block through three commands: seed, replay and scan. The scan chain and the scheduler sit outside the block.

A scan command makes the block raise its scan-enable output and emit one pattern bit per clock for a fixed window. That window is two rows of 256 flip-flops, which is 512 clocks, so that two stimulus vectors can be loaded for launch-on-capture testing. The same scan-enable output is meant to override clock gating on the launch flip-flops while shifting is in progress.

At the moment a scan starts, the block stores the LFSR state in a shadow register. A later replay command copies that stored state back into the LFSR, so the next scan repeats the previous pattern bit for bit. A seed command loads a new value from the seed input. A seed of zero is changed to one, because an all-zero state would lock the LFSR.

Top module: `lfsr_scan_loader`

## Requirements
- R1: Out of reset, `ready_o` is 1 and `scan_en_o` and `scan_bit_o` are 0. The LFSR holds `RESET_SEED`, which defaults to 1.
- R2: If `init_seed_i` is sampled high while the block is ready, the LFSR takes the value of `seed_i`. Each scan bit is LFSR bit 0. On each scan clock the state shifts right by one, and when the bit shifted out is 1 the new state is XORed with `TAP_MASK`. `TAP_MASK` defaults to 32'h8020_0003, the polynomial x^32+x^22+x^2+x+1.
- R3: A seed of all zeros loads the value 1 instead.
- R4: If `start_i` is sampled high while the block is ready, then starting at the next clock `scan_en_o` is 1 and `ready_o` is 0 for exactly `ROW_LEN*NUM_ROWS` consecutive cycles. After that the block is ready again.
- R5: Two scans with no command between them form one continuous bit sequence. The second scan begins at the state the first one ended in.
- R6: The LFSR state at the start of each scan is saved. If `next_seq_i` is sampled high while the block is ready, the LFSR is restored from the saved state, so the next scan repeats the previous one.
- R7: While a scan is running, `init_seed_i`, `next_seq_i` and `start_i` have no effect. The running scan and the sequence that follows it are unchanged.
- R8: When more than one command is sampled in the same ready cycle, only one takes effect: seed before replay, and replay before scan. A start paired with another command does not begin a scan.
- R9: `scan_bit_o` is 0 whenever `scan_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a scan window |
| init_seed_i | input | 1 | Load the LFSR from `seed_i` |
| next_seq_i | input | 1 | Restore the LFSR from the saved state |
| seed_i | input | LFSR_W | Seed value |
| ready_o | output | 1 | Idle and able to accept a command |
| scan_en_o | output | 1 | Scan enable and clock-gating override for the chain |
| scan_bit_o | output | 1 | Serial pattern bit |

## Verification
The bench builds the block with `ROW_LEN` = 8 and `NUM_ROWS` = 2, which gives a 16-clock window. The 32-bit LFSR and its default tap mask are kept. The short window lets many complete scans run: from reset, from a chosen seed, from a zero seed, back to back, and after a replay. Each scan bit is compared against an independent model of the polynomial, and each window length is measured. The same window leaves room to inject commands in the middle of a scan, and to issue command pairs in a single ready cycle and check which one wins.

// File: rtl/lsl_pkg.sv
package lsl_pkg;

   // Command accepted in the current cycle, after priority resolution
   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_SEED   = 2'd1,
      CMD_REPLAY = 2'd2,
      CMD_SCAN   = 2'd3
   } lsl_cmd_e;

   // Width of a down-counter able to hold n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lsl_cmd_arb.sv
module lsl_cmd_arb
   import lsl_pkg::*;
(
   input  logic     idle_i,
   input  logic     seed_req_i,
   input  logic     replay_req_i,
   input  logic     scan_req_i,
   output lsl_cmd_e cmd_o
);

   // Commands are honoured only when idle; seed beats replay beats scan
   always_comb begin
      cmd_o = CMD_NONE;
      if (idle_i) begin
         if (seed_req_i)        cmd_o = CMD_SEED;
         else if (replay_req_i) cmd_o = CMD_REPLAY;
         else if (scan_req_i)   cmd_o = CMD_SCAN;
      end
   end

endmodule

// File: rtl/lsl_lfsr.sv
module lsl_lfsr #(
   parameter int unsigned     LFSR_W     = 32,
   parameter logic [LFSR_W-1:0] TAP_MASK = 32'h8020_0003,
   parameter logic [LFSR_W-1:0] RESET_SEED = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [LFSR_W-1:0] seed_i,
   input  logic              restore_i,
   input  logic [LFSR_W-1:0] restore_val_i,
   input  logic              adv_i,
   output logic [LFSR_W-1:0] state_o,
   output logic              out_bit_o
);

   localparam logic [LFSR_W-1:0] ZERO_SUB = LFSR_W'(1);

   generate
      if (LFSR_W < 2) begin : g_bad_w
         $error("lsl_lfsr: LFSR_W must be at least 2");
      end
      if (TAP_MASK[LFSR_W-1] != 1'b1) begin : g_bad_mask
         $error("lsl_lfsr: TAP_MASK must include the top-degree term");
      end
      if (RESET_SEED == '0) begin : g_bad_rst
         $error("lsl_lfsr: RESET_SEED must be non-zero");
      end
   endgenerate

   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] step;
   logic [LFSR_W-1:0] seed_fix;

   // Galois step: shift right, fold the outgoing bit into the tap positions
   generate
      for (genvar i = 0; i < LFSR_W; i++) begin : g_tap
         if (i == LFSR_W - 1) begin : g_top
            assign step[i] = TAP_MASK[i] & state_q[0];
         end else begin : g_mid
            assign step[i] = state_q[i+1] ^ (TAP_MASK[i] & state_q[0]);
         end
      end
   endgenerate

   assign seed_fix = (seed_i == '0) ? ZERO_SUB : seed_i;

   always_ff @(posedge clk) begin
      if (!rst_n)         state_q <= RESET_SEED;
      else if (load_i)    state_q <= seed_fix;
      else if (restore_i) state_q <= restore_val_i;
      else if (adv_i)     state_q <= step;
   end

   assign state_o   = state_q;
   assign out_bit_o = state_q[0];

   AST_NO_ZERO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0) else $error("LFSR reached zero"); // R3

   AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !restore_i && !adv_i) |=> $stable(state_q))
      else $error("LFSR moved without a cause"); // R7

endmodule

// File: rtl/lsl_shadow.sv
module lsl_shadow #(
   parameter int unsigned       LFSR_W     = 32,
   parameter logic [LFSR_W-1:0] RESET_SEED = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [LFSR_W-1:0] d_i,
   output logic [LFSR_W-1:0] q_o
);

   logic [LFSR_W-1:0] saved_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         saved_q <= RESET_SEED;
      else if (capture_i) saved_q <= d_i;
   end

   assign q_o = saved_q;

   AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(saved_q)) else $error("saved state drifted"); // R6

endmodule

// File: rtl/lsl_scan_seq.sv
module lsl_scan_seq
   import lsl_pkg::*;
#(
   parameter int unsigned SCAN_CYCLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o
);

   localparam int unsigned CNT_W = cnt_width(SCAN_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_CYCLES - 1);

   generate
      if (SCAN_CYCLES < 1) begin : g_bad_len
         $error("lsl_scan_seq: SCAN_CYCLES must be at least 1");
      end
   endgenerate

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (go_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (at_last) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy_o = busy_q;

   AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !at_last) |=> busy_q) else $error("scan cut short"); // R4

   AST_WINDOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && at_last) |=> !busy_q) else $error("scan overran"); // R4

endmodule

// File: rtl/lfsr_scan_loader.sv
module lfsr_scan_loader
   import lsl_pkg::*;
#(
   parameter int unsigned       LFSR_W     = 32,
   parameter logic [LFSR_W-1:0] TAP_MASK   = 32'h8020_0003,
   parameter logic [LFSR_W-1:0] RESET_SEED = 1,
   parameter int unsigned       ROW_LEN    = 256,
   parameter int unsigned       NUM_ROWS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              init_seed_i,
   input  logic              next_seq_i,
   input  logic [LFSR_W-1:0] seed_i,
   output logic              ready_o,
   output logic              scan_en_o,
   output logic              scan_bit_o
);

   localparam int unsigned SCAN_CYCLES = ROW_LEN * NUM_ROWS;

   generate
      if (ROW_LEN < 1 || NUM_ROWS < 1) begin : g_bad_geom
         $error("lfsr_scan_loader: ROW_LEN and NUM_ROWS must be positive");
      end
   endgenerate

   lsl_cmd_e          cmd;
   logic              busy;
   logic [LFSR_W-1:0] lfsr_q;
   logic [LFSR_W-1:0] saved_q;
   logic              lfsr_bit;

   lsl_cmd_arb u_arb (
      .idle_i       (!busy),
      .seed_req_i   (init_seed_i),
      .replay_req_i (next_seq_i),
      .scan_req_i   (start_i),
      .cmd_o        (cmd)
   );

   lsl_lfsr #(
      .LFSR_W     (LFSR_W),
      .TAP_MASK   (TAP_MASK),
      .RESET_SEED (RESET_SEED)
   ) u_lfsr (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (cmd == CMD_SEED),
      .seed_i        (seed_i),
      .restore_i     (cmd == CMD_REPLAY),
      .restore_val_i (saved_q),
      .adv_i         (busy),
      .state_o       (lfsr_q),
      .out_bit_o     (lfsr_bit)
   );

   lsl_shadow #(
      .LFSR_W     (LFSR_W),
      .RESET_SEED (RESET_SEED)
   ) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (cmd == CMD_SCAN),
      .d_i       (lfsr_q),
      .q_o       (saved_q)
   );

   lsl_scan_seq #(
      .SCAN_CYCLES (SCAN_CYCLES)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (cmd == CMD_SCAN),
      .busy_o (busy)
   );

   assign ready_o    = !busy;
   assign scan_en_o  = busy;
   assign scan_bit_o = busy & lfsr_bit;

   AST_SCAN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_en_o) |-> $past(ready_o && start_i && !init_seed_i && !next_seq_i))
      else $error("scan began without an accepted start"); // R8

   AST_REPLAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && next_seq_i && !init_seed_i) |=> (lfsr_q == $past(saved_q)))
      else $error("replay did not restore saved state"); // R6

endmodule

// File: tb/lfsr_scan_loader_tb.sv
module lfsr_scan_loader_tb;

   localparam int          CLK_PERIOD = 10;
   localparam int          ROW_LEN    = 8;
   localparam int          NUM_ROWS   = 2;
   localparam int          SCAN_LEN   = ROW_LEN * NUM_ROWS;
   localparam logic [31:0] MASK       = 32'h8020_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        init_seed_i = 1'b0;
   logic        next_seq_i = 1'b0;
   logic [31:0] seed_i = '0;
   logic        ready_o, scan_en_o, scan_bit_o;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    exp_q[$];
   string cur_req = "R1";
   logic [31:0] m_state;
   logic [31:0] m_saved;
   bit    mon_on = 1'b0;
   int    run_len = 0;
   bit    prev_en = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_scan_loader #(
      .ROW_LEN  (ROW_LEN),
      .NUM_ROWS (NUM_ROWS)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .init_seed_i (init_seed_i),
      .next_seq_i  (next_seq_i),
      .seed_i      (seed_i),
      .ready_o     (ready_o),
      .scan_en_o   (scan_en_o),
      .scan_bit_o  (scan_bit_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] step(input logic [31:0] s);
      return (s >> 1) ^ (s[0] ? MASK : 32'h0);
   endfunction

   // Monitor: pops expected bits while scanning, measures window length
   always @(negedge clk) begin
      if (mon_on) begin
         if (scan_en_o) begin
            run_len++;
            chk(ready_o == 1'b0, "R4 ready low in scan", ready_o, 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, {cur_req, " unexpected scan bit"}, 1, 0);
            end else begin
               automatic bit e = exp_q.pop_front();
               chk(scan_bit_o == e, {cur_req, " scan bit"}, scan_bit_o, e);
            end
         end else begin
            chk(scan_bit_o == 1'b0, "R9 idle bit", scan_bit_o, 0);
            if (prev_en)
               chk(run_len == SCAN_LEN, "R4 window length", run_len, SCAN_LEN);
            run_len = 0;
         end
         prev_en = scan_en_o;
      end
   end

   // Driver: queue expected bits, then issue one start
   task automatic do_scan(input string req);
      cur_req = req;
      chk(ready_o == 1'b1, {req, " ready before start"}, ready_o, 1);
      m_saved = m_state;
      for (int i = 0; i < SCAN_LEN; i++) begin
         exp_q.push_back(m_state[0]);
         m_state = step(m_state);
      end
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse(input bit s, input bit i, input bit n, input logic [31:0] sd);
      start_i = s; init_seed_i = i; next_seq_i = n; seed_i = sd;
      @(negedge clk);
      start_i = 0; init_seed_i = 0; next_seq_i = 0;
   endtask

   task automatic quiet(input string req, input int cycles);
      cur_req = req;
      for (int k = 0; k < cycles; k++) begin
         chk(scan_en_o == 1'b0, {req, " no scan started"}, scan_en_o, 0);
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      m_state = 32'h1;
      m_saved = 32'h1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
      chk(scan_en_o == 1'b0, "R1 scan_en", scan_en_o, 0);
      chk(scan_bit_o == 1'b0, "R1 scan_bit", scan_bit_o, 0);
      mon_on = 1'b1;

      do_scan("R1 reset seed");

      // R2 seed load
      pulse(0, 1, 0, 32'hDEAD_BEEF);
      m_state = 32'hDEAD_BEEF;
      do_scan("R2");

      // R5 continuation
      do_scan("R5");
      do_scan("R5 again");

      // R6 replay of the last scan
      pulse(0, 0, 1, 0);
      m_state = m_saved;
      do_scan("R6");
      pulse(0, 0, 1, 0);
      m_state = m_saved;
      do_scan("R6 repeat");

      // R3 zero seed
      pulse(0, 1, 0, 32'h0);
      m_state = 32'h1;
      do_scan("R3");

      // R7 commands during a scan are ignored
      cur_req = "R7";
      m_saved = m_state;
      for (int i = 0; i < SCAN_LEN; i++) begin
         exp_q.push_back(m_state[0]);
         m_state = step(m_state);
      end
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      pulse(1, 1, 1, 32'h1234_5678);
      pulse(0, 0, 1, 0);
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      do_scan("R7 after");

      // R8 seed beats scan
      pulse(1, 1, 0, 32'hA5A5_0F0F);
      m_state = 32'hA5A5_0F0F;
      quiet("R8 seed+start", 3);
      do_scan("R8 seed won");

      // R8 replay beats scan
      pulse(1, 0, 1, 0);
      m_state = m_saved;
      quiet("R8 replay+start", 3);
      do_scan("R8 replay won");

      // R8 seed beats replay
      pulse(0, 1, 1, 32'h0BAD_F00D);
      m_state = 32'h0BAD_F00D;
      do_scan("R8 seed over replay");

      quiet("R9 idle", 4);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule